// File: doc/BRIEF.md
# Variable Page Size Data Translation Buffer

This block is a fully associative data translation buffer. Each of its entries holds a 64-bit tag and a 64-bit translation word. A lookup presents a 64-bit virtual address, a user/supervisor flag and a load/store flag. The block compares that address against every entry in parallel, using the current 13-bit address-space context. Each entry carries its own page size (8 KB, 64 KB, 512 KB or 4 MB), so each comparator masks off a different number of low address bits.

A lookup ends in one of three ways. It can hit, returning a physical address and access rights. It can fault, when the selected entry is not valid or does not permit the access; the fault sets a sticky status word and captures the faulting address. Or it can miss, when no entry matches. The hit, fault and miss results appear in the same cycle as the request.

Entries are loaded through an index/tag/data write port. When translation is switched off, addresses pass straight through with full data rights. Choosing entries to refill and handling traps are left to the surrounding logic.

Top module: `vpsz_dtlb`

## Requirements
- R1: After reset, the fault status and fault address are zero and every tag and translation word is zero. A lookup with context 0 and an address below 8 KB therefore matches entry 0 and faults, because its valid bit is clear. A lookup with any other context misses.
- R2: Bits 62:61 of a translation word pick the page size: 0 ignores address bits 12:0 in the compare, 1 ignores bits 15:0, 2 ignores bits 18:0 and 3 ignores bits 21:0.
- R3: An entry matches when tag bits 12:0 equal the context input, and the address under the page mask equals the tag with bits 12:0 cleared.
- R4: On a hit, the physical address is (word AND mask AND 0x1FFFFFFF000) + (address AND NOT mask AND 0x1FFFFFFF000).
- R5: A hit always grants read. It grants write only when bit 1 of the word is set.
- R6: A matching entry faults instead of hitting in three cases: bit 63 (valid) is clear, bit 2 (privileged) is set on a user access, or bit 1 (writable) is clear on a store. A fault returns zero address and no rights.
- R7: With translation enabled and no entry matching, a miss is flagged, and at most one of hit, miss and fault is ever high.
- R8: A fault updates the 4-bit status on the next clock edge. If the status was nonzero, it is first replaced by 2 (bit 1 = overflow). The result is then ORed with (user<<3)|(store<<2)|1.
- R9: A fault captures the lookup address into the fault address register on the next edge; otherwise that register holds its value.
- R10: With translation disabled, a valid lookup hits with physical address equal to the virtual address and both rights, never faults or misses, and leaves the status unchanged.
- R11: When several entries match, the lowest-numbered one decides the result.
- R12: An entry write becomes visible to lookups from the next cycle; a lookup in the same cycle as the write sees the old contents.
- R13: The status clear input zeroes the status on the next edge. If a fault arrives in the same cycle, the old status counts as zero, so no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; 0 selects pass-through |
| cur_ctx | input | 13 | Current address-space context |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_store | input | 1 | Lookup is a store |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word (context in bits 12:0) |
| wr_word | input | 64 | Translation word |
| stat_clr | input | 1 | Clear the fault status |
| hit | output | 1 | Translation granted |
| miss | output | 1 | No entry matched |
| fault | output | 1 | Protection or validity fault |
| pa | output | 64 | Physical address on hit |
| may_rd | output | 1 | Read right granted |
| may_wr | output | 1 | Write right granted |
| fstat | output | 4 | Fault status: bit0 fault, bit1 overflow, bit2 store, bit3 user |
| faddr | output | 64 | Captured fault address |

## Verification
Hit, miss, fault, physical address and rights depend only on the inputs and the stored entries, so they are sampled one nanosecond after the inputs change in the same cycle. The fault status and fault address change at the clock edge that follows a faulting or clearing lookup. The bench therefore checks them at the start of the next cycle, against a model that it advances only after the combinational checks of the current cycle are done. Entry writes follow the same rule: the model applies them after the current cycle is checked, so a lookup in the same cycle as a write is compared against the old contents.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
   localparam int TTE_W      = 64;
   localparam int TTE_VALID  = 63;
   localparam int TTE_SZ_HI  = 62;
   localparam int TTE_SZ_LO  = 61;
   localparam int TTE_PRIV   = 2;
   localparam int TTE_WRITE  = 1;
   localparam int BASE_SHIFT = 13;
   localparam int SHIFT_STEP = 3;
   localparam int FS_W       = 4;
   localparam int FS_FLT     = 0;
   localparam int FS_OVF     = 1;
   localparam int FS_STORE   = 2;
   localparam int FS_USER    = 3;

   typedef enum logic [1:0] {PG_8K = 2'd0, PG_64K = 2'd1, PG_512K = 2'd2, PG_4M = 2'd3} pg_size_e;

   function automatic logic [63:0] page_mask(input logic [1:0] sz);
      logic [63:0] m;
      m = '1;
      m = m << (BASE_SHIFT + SHIFT_STEP * int'(sz));
      return m;
   endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store #(
   parameter int N_ENT = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 64,
   parameter int WRD_W = 64
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [WRD_W-1:0]              wr_word,
   output logic [N_ENT-1:0][TAG_W-1:0]   tags,
   output logic [N_ENT-1:0][WRD_W-1:0]   words
);
   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic [TAG_W-1:0] tag_q;
      logic [WRD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q  <= '0;
            word_q <= '0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            tag_q  <= wr_tag;
            word_q <= wr_word;
         end
      end
      assign tags[e]  = tag_q;
      assign words[e] = word_q;
   end
endmodule

// File: rtl/vtlb_match_vec.sv
module vtlb_match_vec import vtlb_pkg::*; #(
   parameter int N_ENT = 64,
   parameter int VA_W  = 64,
   parameter int CTX_W = 13
)(
   input  logic [N_ENT-1:0][VA_W-1:0]  tags,
   input  logic [N_ENT-1:0][TTE_W-1:0] words,
   input  logic [CTX_W-1:0]            ctx,
   input  logic [VA_W-1:0]             va,
   output logic [N_ENT-1:0]            match
);
   localparam logic [VA_W-1:0] CTX_CLR = ~VA_W'((64'd1 << CTX_W) - 64'd1);

   for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      logic [VA_W-1:0] msk;
      assign msk      = VA_W'(page_mask(words[e][TTE_SZ_HI:TTE_SZ_LO]));
      assign match[e] = (tags[e][CTX_W-1:0] == ctx) &&
                        ((va & msk) == (tags[e] & CTX_CLR));
   end
endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick #(
   parameter int N     = 64,
   parameter int IDX_W = 6,
   parameter int STYLE = 0
)(
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   if (STYLE == 0) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
      end
   end else begin : g_isolate
      logic [N-1:0] first;
      assign first = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++)
            if (first[i]) idx = idx | IDX_W'(i);
      end
      always_comb a_r11_single_winner: assert ($onehot0(first));
   end
endmodule

// File: rtl/vtlb_fault_log.sv
module vtlb_fault_log import vtlb_pkg::*; #(
   parameter int VA_W = 64
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            log_en,
   input  logic            clr,
   input  logic            user,
   input  logic            store,
   input  logic [VA_W-1:0] va,
   output logic [FS_W-1:0] fstat,
   output logic [VA_W-1:0] faddr
);
   logic [FS_W-1:0] base, news;

   always_comb begin
      base = '0;
      if (!clr && fstat != '0) base[FS_OVF] = 1'b1;
      news = base;
      news[FS_FLT]   = 1'b1;
      news[FS_STORE] = store;
      news[FS_USER]  = user;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fstat <= '0;
         faddr <= '0;
      end else if (log_en) begin
         fstat <= news;
         faddr <= va;
      end else if (clr) begin
         fstat <= '0;
      end
   end

   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      log_en |=> fstat[FS_FLT]);
   a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (log_en && !clr && fstat != '0) |=> fstat[FS_OVF]);
   a_r8_kind: assert property (@(posedge clk) disable iff (!rst_n)
      log_en |=> (fstat[FS_USER] == $past(user)) && (fstat[FS_STORE] == $past(store)));
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      log_en |=> faddr == $past(va));
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !log_en |=> $stable(faddr));
   a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !log_en) |=> fstat == '0);
   a_r13_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && log_en) |=> !fstat[FS_OVF]);
endmodule

// File: rtl/vpsz_dtlb.sv
module vpsz_dtlb import vtlb_pkg::*; #(
   parameter int N_ENT      = 64,
   parameter int VA_W       = 64,
   parameter int CTX_W      = 13,
   parameter int PA_HI      = 40,
   parameter int PA_LO      = 12,
   parameter int PICK_STYLE = 0
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     xlat_en,
   input  logic [CTX_W-1:0]         cur_ctx,
   input  logic                     lk_valid,
   input  logic [VA_W-1:0]          lk_va,
   input  logic                     lk_user,
   input  logic                     lk_store,
   input  logic                     wr_en,
   input  logic [$clog2(N_ENT)-1:0] wr_idx,
   input  logic [VA_W-1:0]          wr_tag,
   input  logic [TTE_W-1:0]         wr_word,
   input  logic                     stat_clr,
   output logic                     hit,
   output logic                     miss,
   output logic                     fault,
   output logic [VA_W-1:0]          pa,
   output logic                     may_rd,
   output logic                     may_wr,
   output logic [FS_W-1:0]          fstat,
   output logic [VA_W-1:0]          faddr
);
   localparam int IDX_W = $clog2(N_ENT);
   localparam logic [VA_W-1:0] PA_MSK =
      VA_W'(((64'd1 << (PA_HI + 1)) - 64'd1) & ~((64'd1 << PA_LO) - 64'd1));

   if (VA_W != TTE_W) begin : g_bad_va
      $error("VA_W must equal the translation word width");
   end
   if (CTX_W > BASE_SHIFT) begin : g_bad_ctx
      $error("context must fit below the smallest page offset");
   end
   if (N_ENT < 2 || (1 << IDX_W) != N_ENT) begin : g_bad_n
      $error("N_ENT must be a power of two, at least 2");
   end
   if (PA_HI >= 63 || PA_LO >= PA_HI) begin : g_bad_pa
      $error("bad physical address field");
   end

   logic [N_ENT-1:0][VA_W-1:0]  tags;
   logic [N_ENT-1:0][TTE_W-1:0] words;
   logic [N_ENT-1:0]            match;
   logic                        any_match;
   logic [IDX_W-1:0]            sel_idx;
   logic [TTE_W-1:0]            sel;
   logic [VA_W-1:0]             sel_mask;
   logic                        viol, log_en;

   vtlb_store #(.N_ENT(N_ENT), .IDX_W(IDX_W), .TAG_W(VA_W), .WRD_W(TTE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_tag(wr_tag), .wr_word(wr_word), .tags(tags), .words(words));

   vtlb_match_vec #(.N_ENT(N_ENT), .VA_W(VA_W), .CTX_W(CTX_W)) u_match (
      .tags(tags), .words(words), .ctx(cur_ctx), .va(lk_va), .match(match));

   vtlb_pick #(.N(N_ENT), .IDX_W(IDX_W), .STYLE(PICK_STYLE)) u_pick (
      .req(match), .any(any_match), .idx(sel_idx));

   assign sel      = words[sel_idx];
   assign sel_mask = VA_W'(page_mask(sel[TTE_SZ_HI:TTE_SZ_LO]));
   assign viol     = !sel[TTE_VALID] || (sel[TTE_PRIV] && lk_user) ||
                     (!sel[TTE_WRITE] && lk_store);
   assign log_en   = lk_valid && xlat_en && any_match && viol;

   always_comb begin
      hit = 1'b0; miss = 1'b0; fault = 1'b0;
      pa = '0; may_rd = 1'b0; may_wr = 1'b0;
      if (lk_valid) begin
         if (!xlat_en) begin
            hit = 1'b1; pa = lk_va; may_rd = 1'b1; may_wr = 1'b1;
         end else if (!any_match) begin
            miss = 1'b1;
         end else if (viol) begin
            fault = 1'b1;
         end else begin
            hit    = 1'b1;
            pa     = (sel & sel_mask & PA_MSK) + (lk_va & ~sel_mask & PA_MSK);
            may_rd = 1'b1;
            may_wr = sel[TTE_WRITE];
         end
      end
   end

   vtlb_fault_log #(.VA_W(VA_W)) u_flog (
      .clk(clk), .rst_n(rst_n), .log_en(log_en), .clr(stat_clr),
      .user(lk_user), .store(lk_store), .va(lk_va),
      .fstat(fstat), .faddr(faddr));

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit, miss, fault}));
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(hit || miss || fault));
   a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !xlat_en) |-> (hit && pa == lk_va && may_wr));
   a_r10_stat_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !xlat_en && !stat_clr) |=> $stable(fstat));
   a_r5_read_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> may_rd);
   a_r6_fault_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(may_rd || may_wr) && pa == '0);
   a_r8_fault_logged: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fstat[FS_FLT]);
endmodule

// File: tb/vpsz_dtlb_bench.sv
module vpsz_dtlb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xlat_en = 1'b1;
   logic [12:0] cur_ctx = '0;
   logic        lk_valid = 1'b0;
   logic [63:0] lk_va = '0;
   logic        lk_user = 1'b0, lk_store = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_tag = '0, wr_word = '0;
   logic        stat_clr = 1'b0;
   logic        hit, miss, fault, may_rd, may_wr;
   logic [63:0] pa, faddr;
   logic [3:0]  fstat;

   logic [63:0] m_tag [64];
   logic [63:0] m_word[64];
   logic [3:0]  m_fs;
   logic [63:0] m_fa;
   int n_vec = 0, n_bad = 0;
   logic [63:0] pool[8];

   always #2 clk = ~clk;

   vpsz_dtlb u_vpsz_dtlb (
      .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .cur_ctx(cur_ctx),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_user(lk_user), .lk_store(lk_store),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_word(wr_word),
      .stat_clr(stat_clr), .hit(hit), .miss(miss), .fault(fault), .pa(pa),
      .may_rd(may_rd), .may_wr(may_wr), .fstat(fstat), .faddr(faddr));

   function automatic logic [63:0] pmask(input logic [1:0] sz);
      return 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(sz));
   endfunction

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic apply(input string rq);
      logic e_hit, e_miss, e_flt, e_rd, e_wr, found;
      logic [63:0] e_pa, w, mk;
      #1;
      chk("R8", "fault status", {60'd0, fstat}, {60'd0, m_fs});
      chk("R9", "fault address", faddr, m_fa);
      e_hit = 0; e_miss = 0; e_flt = 0; e_rd = 0; e_wr = 0; e_pa = '0;
      if (lk_valid) begin
         if (!xlat_en) begin
            e_hit = 1; e_pa = lk_va; e_rd = 1; e_wr = 1;
         end else begin
            found = 0; w = '0;
            for (int i = 0; i < 64; i++)
               if (!found && m_tag[i][12:0] == cur_ctx &&
                   (lk_va & pmask(m_word[i][62:61])) == (m_tag[i] & ~64'h1FFF)) begin
                  found = 1; w = m_word[i];
               end
            mk = pmask(w[62:61]);
            if (!found) e_miss = 1;
            else if (!w[63] || (w[2] && lk_user) || (!w[1] && lk_store)) e_flt = 1;
            else begin
               e_hit = 1; e_rd = 1; e_wr = w[1];
               e_pa = (w & mk & 64'h1FF_FFFF_F000) + (lk_va & ~mk & 64'h1FF_FFFF_F000);
            end
         end
      end
      chk(rq, "hit", {63'd0, hit}, {63'd0, e_hit});
      chk(rq, "miss", {63'd0, miss}, {63'd0, e_miss});
      chk(rq, "fault", {63'd0, fault}, {63'd0, e_flt});
      chk(rq, "pa", pa, e_pa);
      chk(rq, "rights", {62'd0, may_rd, may_wr}, {62'd0, e_rd, e_wr});
      if (e_flt) begin
         m_fs = ((m_fs != 0 && !stat_clr) ? 4'd2 : 4'd0) | {lk_user, lk_store, 2'b01};
         m_fa = lk_va;
      end else if (stat_clr) m_fs = '0;
      if (wr_en) begin
         m_tag[wr_idx] = wr_tag; m_word[wr_idx] = wr_word;
      end
      @(negedge clk);
   endtask

   task automatic lk(input logic en, input logic [12:0] c, input logic [63:0] va,
                     input logic u, input logic s);
      lk_valid = 1; xlat_en = en; cur_ctx = c; lk_va = va; lk_user = u; lk_store = s;
   endtask

   task automatic wr(input logic [5:0] i, input logic [63:0] t, input logic [63:0] d);
      wr_en = 1; wr_idx = i; wr_tag = t; wr_word = d;
   endtask

   task automatic idle();
      lk_valid = 0; wr_en = 0; stat_clr = 0; xlat_en = 1;
   endtask

   function automatic logic [63:0] mkword(input logic v, input logic [1:0] sz,
                                          input logic [63:0] pbits, input logic pr, input logic w);
      return {v, sz, 61'd0} | (pbits & 64'h1FF_FFFF_F000) | {61'd0, pr, w, 1'b0};
   endfunction

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4077));
      for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_word[i] = '0; end
      m_fs = '0; m_fa = '0;
      for (int i = 0; i < 8; i++) pool[i] = {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFC0_0000;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state; zero entry 0 matches context 0 and faults as invalid
      idle(); lk(1, 13'd0, 64'h0000_0000_0000_1234, 0, 0); apply("R1");
      idle(); lk(1, 13'd5, 64'h0000_0000_0000_1234, 0, 0); apply("R1");
      // R2/R4: 4 MB page, offsets inside and just outside
      idle(); wr(6'd3, 64'h0000_1234_5640_0007, mkword(1, 2'd3, 64'h0AB_CDC0_0000, 0, 1)); apply("R12");
      idle(); lk(1, 13'd7, 64'h0000_1234_567F_FFF8, 0, 1); apply("R2");
      idle(); lk(1, 13'd7, 64'h0000_1234_5680_0000, 0, 0); apply("R2");
      // R3: wrong context misses
      idle(); lk(1, 13'd6, 64'h0000_1234_5640_0010, 0, 0); apply("R3");
      // R11: two overlapping entries, lower index wins
      idle(); wr(6'd9, 64'h0000_0000_0040_0002, mkword(1, 2'd1, 64'h111_1110_0000, 0, 0)); apply("R11");
      idle(); wr(6'd5, 64'h0000_0000_0040_0002, mkword(1, 2'd0, 64'h0EE_EEEE_E000, 0, 1)); apply("R11");
      idle(); lk(1, 13'd2, 64'h0000_0000_0040_1ABC, 0, 0); apply("R11");
      // R12: same-cycle write sees old entry, next cycle new
      idle(); wr(6'd5, 64'h0000_0000_0040_0002, mkword(1, 2'd0, 64'h055_5555_5000, 1, 0));
      lk(1, 13'd2, 64'h0000_0000_0040_0010, 1, 0); apply("R12");
      // R6: privileged user access now faults at entry 5
      idle(); lk(1, 13'd2, 64'h0000_0000_0040_0010, 1, 0); apply("R6");
      // R8: second fault sets overflow; store on read-only
      idle(); lk(1, 13'd2, 64'h0000_0000_0040_0020, 0, 1); apply("R8");
      // R10: disabled pass-through leaves status alone
      idle(); lk(0, 13'd2, 64'hDEAD_BEEF_0040_0020, 1, 1); apply("R10");
      // R13: clear together with a fault gives no overflow, then plain clear
      idle(); stat_clr = 1; lk(1, 13'd2, 64'h0000_0000_0040_0030, 1, 1); apply("R13");
      idle(); stat_clr = 1; apply("R13");
      idle(); apply("R13");
      // R5/R7: random mix
      for (int k = 0; k < 4000; k++) begin
         int e;
         idle();
         if ($urandom_range(0, 4) == 0) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            wr(6'($urandom_range(0, 63)),
               (pool[$urandom_range(0, 7)] | ({32'd0, $urandom()} & 64'h3F_E000 & pmask(sz)))
                  | 64'($urandom_range(0, 3)),
               mkword($urandom_range(0, 7) != 0, sz, {$urandom(), $urandom()},
                      $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1));
         end
         if ($urandom_range(0, 5) != 0) begin
            e = $urandom_range(0, 63);
            lk($urandom_range(0, 19) != 0,
               ($urandom_range(0, 3) == 0) ? 13'($urandom_range(0, 3)) : m_tag[e][12:0],
               (m_tag[e] & ~64'h1FFF) | ({32'd0, $urandom()} & 64'h3F_FFFF),
               $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
         end
         stat_clr = ($urandom_range(0, 19) == 0);
         apply("R7");
      end
      idle(); apply("R5");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule